// File: doc/BRIEF.md
# Alert-on-update line monitor

This block tracks a small set of cache lines for one processor and tells the core when it has lost track of any line it was asked to watch. Each entry of a direct-mapped tag array holds a valid bit, a tag and a watch bit. A marked load looks the line up, allocating it on a miss, and sets the watch bit. A plain load also allocates, but leaves the watch bit unchanged on a hit and clear on a fill.

A watched line can stop being tracked in two ways. A remote processor can take exclusive ownership, which arrives as an invalidation. A local fill can also replace it. The first case raises an alert with a coherence cause and the second with a capacity cause. Each alert gives the core the line address and the handler address that software last wrote into the handler register. After an alert is delivered, further alerts are held back until the core signals handler exit. The first event that arrives while alerts are held back is kept and delivered right after the exit. A clear-all pulse drops every watch bit at once when a transaction finishes.

Top module: `aou_line_monitor`

## Requirements
- R1: After reset `alert_valid` and `alert_target` are 0, every line is invalid with its watch bit clear, alerts are unmasked and the handler register holds 0.
- R2: An invalidation that hits a line whose watch bit is set raises `alert_valid` for one cycle, in the cycle after the invalidation is sampled. It carries `alert_cause` = 0 (coherence) and `alert_line` equal to the invalidated line address.
- R3: An invalidation that hits an unwatched line, or that misses the array, raises no alert.
- R4: A load that misses and replaces a valid watched line raises an alert with `alert_cause` = 1 (capacity) and `alert_line` equal to the address of the replaced line. The array index is the low log2(LINES) bits of a line address and the tag is the remaining upper bits.
- R5: `alert_target` carries the handler register value at the time the alert is delivered. The register is written when `hdl_wr` is high.
- R6: Once an alert is delivered, no further alert appears until `alert_exit` is sampled high.
- R7: The first event that arrives while alerts are masked is kept with its cause and address and delivered in the cycle after `alert_exit` is sampled. Later events during the same masked period are discarded.
- R8: `clear_all` clears every watch bit in one cycle. Invalidations and replacements of those lines then raise no alert, and later marked loads watch lines again.
- R9: When a coherence event and a capacity event occur in the same cycle, the coherence alert is delivered and the capacity event is discarded.
- R10: An invalidation that raises an alert also drops the line. A repeat invalidation raises no alert, and a fill into that index raises no capacity alert.
- R11: A plain load that hits a watched line keeps its watch bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Local load request |
| req_mark | input | 1 | Request is a marked (watching) load |
| req_line | input | ADDR_W | Line address of the load |
| inv_valid | input | 1 | Remote exclusive request invalidates a line |
| inv_line | input | ADDR_W | Line address being invalidated |
| clear_all | input | 1 | Clear every watch bit |
| hdl_wr | input | 1 | Write the handler register |
| hdl_wdata | input | PC_W | Handler address to store |
| alert_exit | input | 1 | Core has left the alert handler |
| alert_valid | output | 1 | One-cycle alert to the core |
| alert_cause | output | 1 | 0 coherence, 1 capacity |
| alert_line | output | ADDR_W | Line address that lost tracking |
| alert_target | output | PC_W | Handler address to redirect to |

## Verification
The bench builds the monitor with LINES = 4, ADDR_W = 12 and PC_W = 16. Four lines make index collisions easy to arrange, so capacity replacements of watched lines, replacements of dropped lines and a coherence event together with a capacity event in the same cycle all need only a few hand-picked addresses. The 16-bit handler width keeps the target values easy to read, and the bench rewrites the register between alerts to show which value each alert picks up.

// File: rtl/aou_pkg.sv
// Shared definitions for the alert-on-update line monitor.
// Assumes: cause encoding is visible on the top-level port as a single bit.
package aou_pkg;
    typedef enum logic {
        CAUSE_COH = 1'b0,   // remote exclusive request took the line
        CAUSE_CAP = 1'b1    // local fill replaced the line
    } aou_cause_e;
endpackage

// File: rtl/aou_tag_array.sv
// Direct-mapped tag array with a watch bit per line; reports lost-tracking events.
// Assumes: LINES is a power of two >= 2; line address = {tag, index}.
// An invalidation is applied before a same-cycle request to the same index.
module aou_tag_array #(
    parameter int LINES  = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_mark,
    input  logic [ADDR_W-1:0] req_line,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_line,
    input  logic              clear_all,
    output logic              coh_evt,
    output logic [ADDR_W-1:0] coh_line,
    output logic              cap_evt,
    output logic [ADDR_W-1:0] cap_line
);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - IDX_W;

    logic [TAG_W-1:0] tag_q [LINES];
    logic [LINES-1:0] vld_q;
    logic [LINES-1:0] mark_q;

    logic [IDX_W-1:0] req_idx, inv_idx;
    logic [TAG_W-1:0] req_tag, inv_tag;
    logic             req_hit, inv_hit;

    // Split addresses and look both ports up against the stored tags.
    always_comb begin
        req_idx = req_line[IDX_W-1:0];
        req_tag = req_line[ADDR_W-1:IDX_W];
        inv_idx = inv_line[IDX_W-1:0];
        inv_tag = inv_line[ADDR_W-1:IDX_W];
        req_hit = vld_q[req_idx] && (tag_q[req_idx] == req_tag);
        inv_hit = vld_q[inv_idx] && (tag_q[inv_idx] == inv_tag);
    end

    // Detect a watched line losing tracking by invalidation or by replacement.
    always_comb begin
        coh_evt  = inv_valid && inv_hit && mark_q[inv_idx];
        coh_line = inv_line;
        cap_evt  = req_valid && !req_hit && vld_q[req_idx] && mark_q[req_idx];
        cap_line = {tag_q[req_idx], req_idx};
    end

    // Update valid and watch bits: clear-all, then invalidation, then request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q  <= '0;
            mark_q <= '0;
        end else begin
            if (clear_all) begin
                mark_q <= '0;
            end
            if (inv_valid && inv_hit) begin
                vld_q[inv_idx]  <= 1'b0;
                mark_q[inv_idx] <= 1'b0;
            end
            if (req_valid) begin
                vld_q[req_idx]  <= 1'b1;
                mark_q[req_idx] <= req_mark |
                                   (req_hit && mark_q[req_idx] && !clear_all);
            end
        end
    end

    // Store the tag of every line a request allocates or hits.
    always_ff @(posedge clk) begin
        if (req_valid) begin
            tag_q[req_idx] <= req_tag;
        end
    end

    // R10: a line that raised a coherence event is gone; a repeat cannot alert.
    a_r10_line_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (coh_evt && !(req_valid && req_line == inv_line))
        |=> !(coh_evt && coh_line == $past(coh_line)));

    // R8: after a clear with no new request, no line is watched.
    a_r8_clear_all: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_all && !req_valid) |=> !(coh_evt || cap_evt));

    // R4: a replaced line shares the request's index but not its address.
    a_r4_cap_same_index: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt |-> (cap_line[IDX_W-1:0] == req_line[IDX_W-1:0]) &&
                    (cap_line != req_line));
endmodule

// File: rtl/aou_alert_ctrl.sv
// Alert controller: masks, holds one pending event, and delivers vectored alerts.
// Assumes: coherence outranks capacity in the same cycle; only the first event
// seen while masked is kept.
module aou_alert_ctrl
    import aou_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int PC_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              coh_evt,
    input  logic [ADDR_W-1:0] coh_line,
    input  logic              cap_evt,
    input  logic [ADDR_W-1:0] cap_line,
    input  logic              alert_exit,
    input  logic              hdl_wr,
    input  logic [PC_W-1:0]   hdl_wdata,
    output logic              alert_valid,
    output aou_cause_e        alert_cause,
    output logic [ADDR_W-1:0] alert_line,
    output logic [PC_W-1:0]   alert_target
);
    logic              masked_q;
    logic              pend_q;
    aou_cause_e        pend_cause_q;
    logic [ADDR_W-1:0] pend_line_q;
    logic [PC_W-1:0]   handler_q;

    logic              new_evt;
    aou_cause_e        new_cause;
    logic [ADDR_W-1:0] new_line;
    logic              open_now, take_pend, take_new, hold_new;

    // Merge this cycle's events with coherence first and choose the action.
    always_comb begin
        new_evt   = coh_evt || cap_evt;
        new_cause = coh_evt ? CAUSE_COH : CAUSE_CAP;
        new_line  = coh_evt ? coh_line : cap_line;
        open_now  = !masked_q || alert_exit;
        take_pend = masked_q && alert_exit && pend_q;
        take_new  = open_now && !take_pend && new_evt;
        hold_new  = new_evt && ((masked_q && !alert_exit && !pend_q) || take_pend);
    end

    // Software-written handler address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            handler_q <= '0;
        end else if (hdl_wr) begin
            handler_q <= hdl_wdata;
        end
    end

    // Mask state and the single pending slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            masked_q     <= 1'b0;
            pend_q       <= 1'b0;
            pend_cause_q <= CAUSE_COH;
            pend_line_q  <= '0;
        end else begin
            if (take_pend || take_new) begin
                masked_q <= 1'b1;
            end else if (alert_exit) begin
                masked_q <= 1'b0;
            end
            if (hold_new) begin
                pend_q       <= 1'b1;
                pend_cause_q <= new_cause;
                pend_line_q  <= new_line;
            end else if (take_pend) begin
                pend_q <= 1'b0;
            end
        end
    end

    // Alert outputs registered one cycle after the event is chosen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alert_valid  <= 1'b0;
            alert_cause  <= CAUSE_COH;
            alert_line   <= '0;
            alert_target <= '0;
        end else begin
            alert_valid <= take_pend || take_new;
            if (take_pend) begin
                alert_cause  <= pend_cause_q;
                alert_line   <= pend_line_q;
                alert_target <= handler_q;
            end else if (take_new) begin
                alert_cause  <= new_cause;
                alert_line   <= new_line;
                alert_target <= handler_q;
            end
        end
    end

    // R6: a masked period without exit never produces an alert.
    a_r6_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_q && !alert_exit) |=> !alert_valid);

    // R6: a delivered alert leaves the controller masked.
    a_r6_mask_after_alert: assert property (@(posedge clk) disable iff (!rst_n)
        alert_valid |-> masked_q);

    // R5: the target is the handler register value seen when the alert was taken.
    a_r5_target: assert property (@(posedge clk) disable iff (!rst_n)
        alert_valid |-> alert_target == $past(handler_q));

    // R7: exit with a pending event delivers it on the next cycle.
    a_r7_pending_delivery: assert property (@(posedge clk) disable iff (!rst_n)
        (masked_q && alert_exit && pend_q)
        |=> alert_valid && alert_line == $past(pend_line_q));

    // R9: simultaneous events while unmasked deliver the coherence cause.
    a_r9_coh_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (coh_evt && cap_evt && !masked_q)
        |=> alert_valid && alert_cause == CAUSE_COH);
endmodule

// File: rtl/aou_line_monitor.sv
// Top: watched-line tag array plus alert controller for one processor.
// Assumes: one load and one invalidation per cycle at most; LINES power of two.
module aou_line_monitor #(
    parameter int LINES  = 8,
    parameter int ADDR_W = 16,
    parameter int PC_W   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_mark,
    input  logic [ADDR_W-1:0] req_line,
    input  logic              inv_valid,
    input  logic [ADDR_W-1:0] inv_line,
    input  logic              clear_all,
    input  logic              hdl_wr,
    input  logic [PC_W-1:0]   hdl_wdata,
    input  logic              alert_exit,
    output logic              alert_valid,
    output logic              alert_cause,
    output logic [ADDR_W-1:0] alert_line,
    output logic [PC_W-1:0]   alert_target
);
    logic              coh_evt, cap_evt;
    logic [ADDR_W-1:0] coh_line, cap_line;
    aou_pkg::aou_cause_e cause_e;

    aou_tag_array #(.LINES(LINES), .ADDR_W(ADDR_W)) u_tags (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_mark  (req_mark),
        .req_line  (req_line),
        .inv_valid (inv_valid),
        .inv_line  (inv_line),
        .clear_all (clear_all),
        .coh_evt   (coh_evt),
        .coh_line  (coh_line),
        .cap_evt   (cap_evt),
        .cap_line  (cap_line)
    );

    aou_alert_ctrl #(.ADDR_W(ADDR_W), .PC_W(PC_W)) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .coh_evt      (coh_evt),
        .coh_line     (coh_line),
        .cap_evt      (cap_evt),
        .cap_line     (cap_line),
        .alert_exit   (alert_exit),
        .hdl_wr       (hdl_wr),
        .hdl_wdata    (hdl_wdata),
        .alert_valid  (alert_valid),
        .alert_cause  (cause_e),
        .alert_line   (alert_line),
        .alert_target (alert_target)
    );

    assign alert_cause = cause_e;
endmodule

// File: tb/aou_line_monitor_tb.sv
`timescale 1ns/1ps
module aou_line_monitor_tb;
    localparam int LINES  = 4;
    localparam int ADDR_W = 12;
    localparam int PC_W   = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0, req_mark = 1'b0;
    logic [ADDR_W-1:0] req_line = '0;
    logic              inv_valid = 1'b0;
    logic [ADDR_W-1:0] inv_line = '0;
    logic              clear_all = 1'b0, hdl_wr = 1'b0, alert_exit = 1'b0;
    logic [PC_W-1:0]   hdl_wdata = '0;
    logic              alert_valid, alert_cause;
    logic [ADDR_W-1:0] alert_line;
    logic [PC_W-1:0]   alert_target;

    aou_line_monitor #(.LINES(LINES), .ADDR_W(ADDR_W), .PC_W(PC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mark(req_mark),
        .req_line(req_line), .inv_valid(inv_valid), .inv_line(inv_line),
        .clear_all(clear_all), .hdl_wr(hdl_wr), .hdl_wdata(hdl_wdata),
        .alert_exit(alert_exit), .alert_valid(alert_valid),
        .alert_cause(alert_cause), .alert_line(alert_line),
        .alert_target(alert_target)
    );

    always #2.5 clk = ~clk;   // 200 MHz

    typedef struct {
        logic              cause;
        logic [ADDR_W-1:0] line;
        logic [PC_W-1:0]   target;
        string             req;
    } exp_t;

    exp_t  exp_q[$];
    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";
    bit    done = 1'b0;
    logic [PC_W-1:0] handler_model = '0;

    localparam logic COH = 1'b0;
    localparam logic CAP = 1'b1;

    // Monitor: every alert must match the head of the expected queue.
    always @(negedge clk) begin
        if (rst_n && alert_valid) begin
            exp_t e;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL %s: unexpected alert cause=%0d line=%h, expected no alert",
                         cur_req, alert_cause, alert_line);
            end else begin
                e = exp_q.pop_front();
                if (alert_cause !== e.cause || alert_line !== e.line ||
                    alert_target !== e.target) begin
                    errors++;
                    $display("FAIL %s: alert cause=%0d line=%h target=%h, expected cause=%0d line=%h target=%h",
                             e.req, alert_cause, alert_line, alert_target,
                             e.cause, e.line, e.target);
                end
            end
        end
    end

    task automatic push(input logic c, input logic [ADDR_W-1:0] l, input string r);
        exp_t e;
        e.cause = c; e.line = l; e.target = handler_model; e.req = r;
        exp_q.push_back(e);
    endtask

    task automatic load(input logic [ADDR_W-1:0] a, input logic m);
        @(negedge clk);
        req_valid = 1'b1; req_mark = m; req_line = a;
        @(negedge clk);
        req_valid = 1'b0; req_mark = 1'b0;
    endtask

    task automatic inv(input logic [ADDR_W-1:0] a);
        @(negedge clk);
        inv_valid = 1'b1; inv_line = a;
        @(negedge clk);
        inv_valid = 1'b0;
    endtask

    task automatic clear();
        @(negedge clk);
        clear_all = 1'b1;
        @(negedge clk);
        clear_all = 1'b0;
    endtask

    task automatic exit_h();
        @(negedge clk);
        alert_exit = 1'b1;
        @(negedge clk);
        alert_exit = 1'b0;
    endtask

    task automatic wr_handler(input logic [PC_W-1:0] v);
        @(negedge clk);
        hdl_wr = 1'b1; hdl_wdata = v;
        @(negedge clk);
        hdl_wr = 1'b0;
        handler_model = v;
    endtask

    // Wait, then require every expected alert to have arrived.
    task automatic settle();
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL %s: %0d expected alert(s) missing, expected 0 outstanding",
                     cur_req, exp_q.size());
            exp_q.delete();
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Watchdog ends a hung run as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        checks++;
        if (alert_valid !== 1'b0 || alert_target !== '0) begin
            errors++;
            $display("FAIL R1: alert_valid=%0d target=%h, expected 0 and 0",
                     alert_valid, alert_target);
        end
        rst_n = 1'b1;
        cur_req = "R1";
        inv(12'h010);          // R1: empty array, no alert
        settle();

        wr_handler(16'hABCD);

        // R2: marked line invalidated -> coherence alert
        cur_req = "R2";
        load(12'h010, 1'b1);
        push(COH, 12'h010, "R2");
        inv(12'h010);
        settle();
        exit_h();

        // R3: unwatched hit and miss invalidations are silent
        cur_req = "R3";
        load(12'h020, 1'b0);
        inv(12'h020);
        inv(12'h0F0);
        settle();

        // R11: plain load hit keeps watch bit
        cur_req = "R11";
        load(12'h081, 1'b1);
        load(12'h081, 1'b0);
        push(COH, 12'h081, "R11");
        inv(12'h081);
        settle();
        exit_h();

        // R4: replacement of watched line -> capacity alert with old address
        cur_req = "R4";
        load(12'h032, 1'b1);
        push(CAP, 12'h032, "R4");
        load(12'h042, 1'b0);
        settle();
        exit_h();

        // R5: target follows the rewritten handler register
        wr_handler(16'h1234);
        cur_req = "R5";
        load(12'h013, 1'b1);
        push(COH, 12'h013, "R5");
        inv(12'h013);
        settle();
        exit_h();

        // R6 / R7: masking and the pending slot
        cur_req = "R6";
        load(12'h110, 1'b1);
        load(12'h111, 1'b1);
        load(12'h112, 1'b1);
        push(COH, 12'h110, "R6");
        inv(12'h110);
        inv(12'h111);            // masked: becomes pending
        load(12'h122, 1'b0);     // masked, slot full: discarded
        settle();
        cur_req = "R7";
        push(COH, 12'h111, "R7");
        exit_h();
        checks++;
        if (alert_valid !== 1'b1) begin
            errors++;
            $display("FAIL R7: alert_valid=%0d in cycle after exit, expected 1", alert_valid);
        end
        settle();
        exit_h();
        settle();                // R7: discarded capacity event never appears

        // R9: coherence and capacity in the same cycle
        cur_req = "R9";
        load(12'h133, 1'b1);
        load(12'h131, 1'b1);
        push(COH, 12'h133, "R9");
        @(negedge clk);
        inv_valid = 1'b1; inv_line = 12'h133;
        req_valid = 1'b1; req_mark = 1'b0; req_line = 12'h145;
        @(negedge clk);
        inv_valid = 1'b0; req_valid = 1'b0;
        settle();
        exit_h();
        settle();                // R9: capacity event was discarded

        // R8: clear-all drops all watches, new marks still work
        cur_req = "R8";
        load(12'h150, 1'b1);
        load(12'h151, 1'b1);
        clear();
        inv(12'h150);
        load(12'h161, 1'b0);
        settle();
        load(12'h170, 1'b1);
        push(COH, 12'h170, "R8");
        inv(12'h170);
        settle();
        exit_h();

        // R10: alerted line is dropped
        cur_req = "R10";
        load(12'h180, 1'b1);
        push(COH, 12'h180, "R10");
        inv(12'h180);
        settle();
        exit_h();
        inv(12'h180);
        load(12'h190, 1'b0);
        settle();

        done = 1'b1;
        summary();
        $finish;
    end
endmodule